// File: doc/BRIEF.md
# SCSI Pseudo-DMA Handshake Engine

This block carries a run of bytes between a host-side DMA request/acknowledge pair and the REQ/ACK handshake of a SCSI bus. A neighbouring register-interface block decodes software accesses. It passes this engine three start strobes (send, target-role receive, initiator-role receive), the enable and option bits from its mode register, and the phase value that software expects. Writing any value to one of the start addresses produces the strobe, so no data travels with it.

For each byte the engine requests service from the host with `drq` and accepts the host's `hostDack`. On the SCSI side it drives ACK when it is the initiator and REQ when it is the target, and paces itself on the peer's opposite line. Incoming bytes are latched as the peer's strobe becomes active. The host marks the final byte by pulsing `hostEop` with its acknowledge. The engine raises `endDma` once that byte's handshake is finished, and for a send it also raises `lastByteSent`. If the bus phase departs from the expected phase while a transfer is running, the engine stops at once, flags the error and interrupts. Clearing the DMA enable drops every handshake line in the same cycle. All SCSI lines here are active-high logical levels: "asserted" means the signal is true on the bus.

Top module: `pdma_engine`

## Requirements
- R1: A start strobe is accepted only while `dmaModeEn` is high and no transfer is active. When several strobes arrive together, send wins over target receive, and target receive wins over initiator receive. A send takes its role from `targetRole` (1 = target). A strobe that is not accepted leaves `active` and all handshake outputs unchanged.
- R2: Initiator receive. When REQ is asserted, the byte on `busDataIn` is latched into `inputData` and `drq` rises. The cycle after `hostDack`, `busAckOut` is asserted. The cycle after REQ is released, `busAckOut` is released.
- R3: Initiator send. `hostDack` loads `hostDataIn` into `busDataOut`, and `busDataOe` stays high for the whole transfer. The cycle after REQ is asserted, `busAckOut` is asserted. It is released the cycle after REQ is released.
- R4: Target send. The cycle after `hostDack`, `busReqOut` is asserted with the host byte on `busDataOut`. `busReqOut` is released the cycle after ACK is asserted. The next byte is requested after ACK is released.
- R5: Target receive. `busReqOut` is asserted when the transfer starts. When ACK is asserted, `busDataIn` is latched and `busReqOut` is released. `drq` rises after ACK is released.
- R6: With `blockMode` low, `drq` is high only while the engine waits for the host. With `blockMode` high, `drq` stays high for the whole active transfer.
- R7: `hostEop` sampled with `hostDack` marks the final byte. After that byte's handshake completes, `active` falls and `endDma` rises.
- R8: `lastByteSent` rises together with `endDma` on sends only. A receive leaves it low.
- R9: While a transfer is active, `busPhase` differing from `expPhase` ends the transfer on the next edge. `phaseErr` and `irq` are set, and `drq`, `busAckOut` and `busReqOut` are low.
- R10: The normal end of a transfer sets `irq` only if `eopIntEn` is high.
- R11: Clearing `dmaModeEn` drops `drq`, `busAckOut` and `busReqOut` in the same cycle. On the next edge the engine is idle.
- R12: An accepted start strobe clears `endDma`, `lastByteSent`, `phaseErr` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dmaModeEn | input | 1 | DMA mode enable from the mode register |
| blockMode | input | 1 | Hold drq for the whole transfer |
| eopIntEn | input | 1 | Interrupt on normal end of transfer |
| targetRole | input | 1 | Role for a send: 1 target, 0 initiator |
| strobeSend | input | 1 | Start a send |
| strobeTgtRecv | input | 1 | Start a target-role receive |
| strobeIniRecv | input | 1 | Start an initiator-role receive |
| expPhase | input | 3 | Programmed bus phase |
| busPhase | input | 3 | Observed bus phase |
| busReqIn | input | 1 | REQ seen on the bus |
| busAckIn | input | 1 | ACK seen on the bus |
| busDataIn | input | 8 | Data seen on the bus |
| hostDack | input | 1 | Host DMA acknowledge, one cycle |
| hostEop | input | 1 | Final-byte marker, valid with hostDack |
| hostDataIn | input | 8 | Byte from the host for a send |
| drq | output | 1 | DMA request to the host |
| busAckOut | output | 1 | ACK driven as initiator |
| busReqOut | output | 1 | REQ driven as target |
| busDataOut | output | 8 | Byte driven on the bus during a send |
| busDataOe | output | 1 | Data output enable |
| inputData | output | 8 | Last byte latched from the bus |
| endDma | output | 1 | Transfer ended normally |
| lastByteSent | output | 1 | Final byte of a send handshaken |
| phaseErr | output | 1 | Transfer aborted on phase mismatch |
| irq | output | 1 | Interrupt request |
| active | output | 1 | Transfer in progress |

## Verification
The hardest states to reach from the ports are the interrupted ones: a phase change in the middle of a byte while the engine holds ACK, and a loss of DMA enable while REQ is driven. Both need a transfer parked at an exact handshake step. The bench reaches them by driving the peer side of the bus one step at a time, then flipping `busPhase` or `dmaModeEn` at that point. Randomized runs mix the four transfer kinds, lengths, byte values, block mode and the end interrupt enable, and insert random idle gaps before each peer strobe.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  // handshake step of the engine
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HOST     = 2'd1,  // waiting for hostDack
    ST_PEER_ON  = 2'd2,  // waiting for peer strobe to assert
    ST_PEER_OFF = 2'd3   // waiting for peer strobe to release
  } stepT;

  // control to datapath strobes
  typedef struct packed {
    logic loadOut;    // take host byte for the bus
    logic captureIn;  // take bus byte for the host
  } dpStrobeT;
endpackage

// File: rtl/pdma_datapath.sv
module pdma_datapath
  import pdma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          dpCtl,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] inputData
);
  logic [DATA_W-1:0] outByteQ;
  logic [DATA_W-1:0] inByteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outByteQ <= '0;
      inByteQ  <= '0;
    end else begin
      if (dpCtl.loadOut)   outByteQ <= hostDataIn;
      if (dpCtl.captureIn) inByteQ  <= busDataIn;
    end
  end

  assign busDataOut = outByteQ;
  assign inputData  = inByteQ;
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dmaModeEn,
  input  logic               blockMode,
  input  logic               eopIntEn,
  input  logic               targetRole,
  input  logic               strobeSend,
  input  logic               strobeTgtRecv,
  input  logic               strobeIniRecv,
  input  logic [PHASE_W-1:0] expPhase,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic               busReqIn,
  input  logic               busAckIn,
  input  logic               hostDack,
  input  logic               hostEop,
  output dpStrobeT           dpCtl,
  output logic               drq,
  output logic               busAckOut,
  output logic               busReqOut,
  output logic               busDataOe,
  output logic               endDma,
  output logic               lastByteSent,
  output logic               phaseErr,
  output logic               irq,
  output logic               active
);
  stepT stepQ, stepD;
  logic isTgtQ, isSendQ, eopSeenQ, eopSeenD;
  logic endQ, lbsQ, perrQ, irqQ;
  logic peerLine, xferOn, phaseBad, anyStrobe, startOk, finishNow, abortNow;
  logic startTgt;

  assign xferOn    = (stepQ != ST_IDLE);
  assign peerLine  = isTgtQ ? busAckIn : busReqIn;
  assign phaseBad  = (busPhase != expPhase);
  assign anyStrobe = strobeSend | strobeTgtRecv | strobeIniRecv;
  assign startOk   = dmaModeEn && !xferOn && anyStrobe;
  assign startTgt  = strobeSend ? targetRole : strobeTgtRecv;

  always_comb begin
    stepD     = stepQ;
    eopSeenD  = eopSeenQ;
    dpCtl     = '0;
    finishNow = 1'b0;
    abortNow  = 1'b0;
    unique case (stepQ)
      ST_IDLE: begin
        if (startOk) stepD = strobeSend ? ST_HOST : ST_PEER_ON;
      end
      ST_HOST: begin
        if (hostDack) begin
          if (isSendQ) begin
            dpCtl.loadOut = 1'b1;
            eopSeenD      = hostEop;
            stepD         = ST_PEER_ON;
          end else if (isTgtQ) begin
            if (hostEop) finishNow = 1'b1;
            else         stepD     = ST_PEER_ON;
          end else begin
            eopSeenD = hostEop;
            stepD    = ST_PEER_OFF;
          end
        end
      end
      ST_PEER_ON: begin
        if (peerLine) begin
          if (isSendQ) begin
            stepD = ST_PEER_OFF;
          end else begin
            dpCtl.captureIn = 1'b1;
            stepD = isTgtQ ? ST_PEER_OFF : ST_HOST;
          end
        end
      end
      ST_PEER_OFF: begin
        if (!peerLine) begin
          if (isSendQ) begin
            if (eopSeenQ) finishNow = 1'b1;
            else          stepD     = ST_HOST;
          end else if (isTgtQ) begin
            stepD = ST_HOST;
          end else begin
            if (eopSeenQ) finishNow = 1'b1;
            else          stepD     = ST_PEER_ON;
          end
        end
      end
      default: stepD = ST_IDLE;
    endcase
    if (finishNow) stepD = ST_IDLE;
    if (xferOn && phaseBad) begin
      stepD     = ST_IDLE;
      abortNow  = 1'b1;
      finishNow = 1'b0;
      dpCtl     = '0;
    end
    if (!dmaModeEn) begin
      stepD     = ST_IDLE;
      abortNow  = 1'b0;
      finishNow = 1'b0;
      dpCtl     = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ    <= ST_IDLE;
      isTgtQ   <= 1'b0;
      isSendQ  <= 1'b0;
      eopSeenQ <= 1'b0;
      endQ     <= 1'b0;
      lbsQ     <= 1'b0;
      perrQ    <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      stepQ    <= stepD;
      eopSeenQ <= eopSeenD;
      if (startOk) begin
        isTgtQ   <= startTgt;
        isSendQ  <= strobeSend;
        eopSeenQ <= 1'b0;
        endQ     <= 1'b0;
        lbsQ     <= 1'b0;
        perrQ    <= 1'b0;
        irqQ     <= 1'b0;
      end
      if (finishNow) begin
        endQ <= 1'b1;
        lbsQ <= isSendQ;
        irqQ <= irqQ | eopIntEn;
      end
      if (abortNow) begin
        perrQ <= 1'b1;
        irqQ  <= 1'b1;
      end
    end
  end

  assign drq          = dmaModeEn && (blockMode ? xferOn : (stepQ == ST_HOST));
  assign busAckOut    = dmaModeEn && !isTgtQ && (stepQ == ST_PEER_OFF);
  assign busReqOut    = dmaModeEn && isTgtQ && (stepQ == ST_PEER_ON);
  assign busDataOe    = dmaModeEn && xferOn && isSendQ;
  assign endDma       = endQ;
  assign lastByteSent = lbsQ;
  assign phaseErr     = perrQ;
  assign irq          = irqQ;
  assign active       = xferOn;
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dmaModeEn,
  input  logic               blockMode,
  input  logic               eopIntEn,
  input  logic               targetRole,
  input  logic               strobeSend,
  input  logic               strobeTgtRecv,
  input  logic               strobeIniRecv,
  input  logic [PHASE_W-1:0] expPhase,
  input  logic [PHASE_W-1:0] busPhase,
  input  logic               busReqIn,
  input  logic               busAckIn,
  input  logic [DATA_W-1:0]  busDataIn,
  input  logic               hostDack,
  input  logic               hostEop,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic               drq,
  output logic               busAckOut,
  output logic               busReqOut,
  output logic [DATA_W-1:0]  busDataOut,
  output logic               busDataOe,
  output logic [DATA_W-1:0]  inputData,
  output logic               endDma,
  output logic               lastByteSent,
  output logic               phaseErr,
  output logic               irq,
  output logic               active
);
  dpStrobeT dpCtl;

  pdma_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dmaModeEn(dmaModeEn), .blockMode(blockMode),
    .eopIntEn(eopIntEn), .targetRole(targetRole), .strobeSend(strobeSend),
    .strobeTgtRecv(strobeTgtRecv), .strobeIniRecv(strobeIniRecv),
    .expPhase(expPhase), .busPhase(busPhase), .busReqIn(busReqIn),
    .busAckIn(busAckIn), .hostDack(hostDack), .hostEop(hostEop),
    .dpCtl(dpCtl), .drq(drq), .busAckOut(busAckOut), .busReqOut(busReqOut),
    .busDataOe(busDataOe), .endDma(endDma), .lastByteSent(lastByteSent),
    .phaseErr(phaseErr), .irq(irq), .active(active)
  );

  pdma_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .hostDataIn(hostDataIn),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .inputData(inputData)
  );
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               dmaModeEn,
  input logic               eopIntEn,
  input logic [PHASE_W-1:0] expPhase,
  input logic [PHASE_W-1:0] busPhase,
  input logic               busReqIn,
  input logic               busAckOut,
  input logic               active,
  input logic               endDma,
  input logic               lastByteSent,
  input logic               phaseErr,
  input logic               irq
);
  AST_IDLE_WITHOUT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !dmaModeEn) |=> !active); // R1
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busAckOut && !busReqIn && dmaModeEn) |=> !busAckOut); // R2
  AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endDma) |-> !active); // R7
  AST_LBS_WITH_END: assert property (@(posedge clk) disable iff (!rstN)
    lastByteSent |-> endDma); // R8
  AST_PHASE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (active && dmaModeEn && (busPhase != expPhase)) |=> (!active && phaseErr && irq)); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (phaseErr || $past(eopIntEn))); // R10
  AST_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaModeEn) |=> !active); // R11
endmodule

bind pdma_engine pdma_checker #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/sim_pdma_engine.sv
`timescale 1ns/1ps
module sim_pdma_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaModeEn = 1'b1, blockMode = 1'b0, eopIntEn = 1'b1, targetRole = 1'b0;
  logic strobeSend = 1'b0, strobeTgtRecv = 1'b0, strobeIniRecv = 1'b0;
  logic [2:0] expPhase = 3'd1, busPhase = 3'd1;
  logic busReqIn = 1'b0, busAckIn = 1'b0, hostDack = 1'b0, hostEop = 1'b0;
  logic [7:0] busDataIn = '0, hostDataIn = '0;
  logic drq, busAckOut, busReqOut, busDataOe, endDma, lastByteSent, phaseErr, irq, active;
  logic [7:0] busDataOut, inputData;
  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pdma_engine u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected drq while the engine is not waiting on the host
  function automatic logic expDrqOther(logic blk);
    return blk;
  endfunction
  // expected irq after a normal finish
  function automatic logic expEndIrq(logic en);
    return en;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic gap();
    int g = $urandom % 3;
    for (int k = 0; k < g; k++) tick();
  endtask

  // kind 0 send, 1 target receive, 2 initiator receive
  task automatic startX(int kind);
    strobeSend = (kind == 0); strobeTgtRecv = (kind == 1); strobeIniRecv = (kind == 2);
    tick();
    strobeSend = 0; strobeTgtRecv = 0; strobeIniRecv = 0;
    chk("R1 active after start", active, 1);
    chk("R12 endDma cleared", endDma, 0);
    chk("R12 irq cleared", irq, 0);
  endtask

  task automatic hostAck(logic [7:0] d, logic last);
    hostDack = 1; hostEop = last; hostDataIn = d;
    tick();
    hostDack = 0; hostEop = 0;
  endtask

  task automatic finishChecks(logic isSend);
    chk("R7 endDma", endDma, 1);
    chk("R7 idle", active, 0);
    chk("R8 lastByteSent", lastByteSent, isSend);
    chk("R10 irq", irq, expEndIrq(eopIntEn));
  endtask

  task automatic iniRecv(int n);
    startX(2);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      gap();
      chk("R6 drq waiting for REQ", drq, expDrqOther(blockMode));
      busDataIn = d; busReqIn = 1;
      tick();
      chk("R2 capture", inputData, d);
      chk("R2 drq", drq, 1);
      chk("R2 ack low before dack", busAckOut, 0);
      hostAck(8'h00, i == n - 1);
      chk("R2 ack asserted", busAckOut, 1);
      gap();
      busReqIn = 0;
      tick();
      chk("R2 ack released", busAckOut, 0);
      if (i == n - 1) finishChecks(0);
      else chk("R7 not ended", endDma, 0);
    end
  endtask

  task automatic iniSend(int n);
    targetRole = 0;
    startX(0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      chk("R6 drq host wait", drq, 1);
      hostAck(d, i == n - 1);
      chk("R3 data out", busDataOut, d);
      chk("R3 oe", busDataOe, 1);
      chk("R6 drq", drq, expDrqOther(blockMode));
      gap();
      busReqIn = 1;
      tick();
      chk("R3 ack asserted", busAckOut, 1);
      busReqIn = 0;
      tick();
      chk("R3 ack released", busAckOut, 0);
      if (i == n - 1) finishChecks(1);
    end
  endtask

  task automatic tgtSend(int n);
    targetRole = 1;
    startX(0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      chk("R6 drq host wait", drq, 1);
      hostAck(d, i == n - 1);
      chk("R4 req asserted", busReqOut, 1);
      chk("R4 data out", busDataOut, d);
      gap();
      busAckIn = 1;
      tick();
      chk("R4 req released", busReqOut, 0);
      busAckIn = 0;
      tick();
      if (i == n - 1) finishChecks(1);
    end
  endtask

  task automatic tgtRecv(int n);
    startX(1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      gap();
      chk("R5 req asserted", busReqOut, 1);
      busDataIn = d; busAckIn = 1;
      tick();
      chk("R5 req released", busReqOut, 0);
      chk("R5 capture", inputData, d);
      busAckIn = 0;
      tick();
      chk("R5 drq", drq, 1);
      hostAck(8'h00, i == n - 1);
      if (i == n - 1) finishChecks(0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    tick(); tick();
    chk("R1 reset active", active, 0);
    chk("R6 reset drq", drq, 0);
    chk("R7 reset endDma", endDma, 0);
    chk("R9 reset irq", irq, 0);
    rstN = 1;
    tick();

    iniRecv(3); iniSend(2); tgtSend(2); tgtRecv(3);

    // R1: strobe ignored without DMA mode
    dmaModeEn = 0;
    strobeIniRecv = 1; tick(); strobeIniRecv = 0;
    chk("R1 ignored without mode", active, 0);
    dmaModeEn = 1; tick();
    chk("R1 still idle", active, 0);
    chk("R1 no req", busReqOut, 0);

    // R1 priority: send beats receive strobes, target role
    targetRole = 1;
    strobeSend = 1; strobeIniRecv = 1; strobeTgtRecv = 1; tick();
    strobeSend = 0; strobeIniRecv = 0; strobeTgtRecv = 0;
    chk("R1 priority send drq", drq, 1);
    chk("R1 priority send oe", busDataOe, 1);
    // abort with mode clear while waiting for host
    dmaModeEn = 0; #1;
    chk("R11 drq dropped", drq, 0);
    tick(); dmaModeEn = 1;
    chk("R11 idle", active, 0);

    // R1: strobe ignored while busy; R11 with REQ driven
    startX(1);
    chk("R5 req", busReqOut, 1);
    strobeSend = 1; tick(); strobeSend = 0;
    chk("R1 busy ignore req", busReqOut, 1);
    chk("R1 busy ignore oe", busDataOe, 0);
    dmaModeEn = 0; #1;
    chk("R11 req dropped", busReqOut, 0);
    tick(); dmaModeEn = 1;
    chk("R11 idle after clear", active, 0);

    // R9: mismatch while ACK held
    startX(2);
    busReqIn = 1; tick();
    hostAck(8'h00, 0);
    chk("R2 ack held", busAckOut, 1);
    busPhase = 3'd5; tick();
    chk("R9 idle", active, 0);
    chk("R9 phaseErr", phaseErr, 1);
    chk("R9 irq", irq, 1);
    chk("R9 ack low", busAckOut, 0);
    busPhase = expPhase; busReqIn = 0; tick();
    startX(1);
    chk("R12 phaseErr cleared", phaseErr, 0);
    dmaModeEn = 0; tick(); dmaModeEn = 1; tick();

    // R10 directed: no end interrupt when disabled
    eopIntEn = 0; tgtRecv(1); eopIntEn = 1;

    for (int r = 0; r < 14; r++) begin
      int kind = $urandom % 4;
      int n = 1 + ($urandom % 4);
      blockMode = 1'($urandom);
      eopIntEn = 1'($urandom);
      case (kind)
        0: iniRecv(n);
        1: iniSend(n);
        2: tgtSend(n);
        default: tgtRecv(n);
      endcase
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule